// File: doc/BRIEF.md
# 64-bit SECDED Word Checker

This block checks one 64-bit data word, presented as two 32-bit halves, against an 8-bit check byte read alongside it. From the data it computes a fresh check byte using a fixed table of column masks. It XORs that byte with the received check byte to form a syndrome. It then classifies the syndrome as no error, a single error (in a data bit or a check bit) or a multi-bit error.

For a single data-bit error the block names the failing bit and returns the repaired word. For a check-bit error it names the failing check bit. All results are registered and appear one clock after the input strobe, together with a result-valid flag.

A memory read path or an error handler places the block after the point where data and check bits are captured. It is used wherever a word must be classified and repaired.

Top module: `secded64_checker`

## Requirements
- R1: Generated check bit i is the XOR of the data bits selected by mask pair i, where each pair is (mask over data[63:32], mask over data[31:0]): bit 0 = f00fe11e/c33c0ff7, bit 1 = 00ff00ff/00fff0ff, bit 2 = 0f0f0f0f/0f0fff00, bit 3 = 11113333/7777000f, bit 4 = 22224444/8888222f, bit 5 = 44448888/ffff4441, bit 6 = 8888ffff/11118882, bit 7 = ffff1111/22221114.
- R2: The syndrome output equals the generated check byte XOR the received check byte.
- R3: The column of data bit n is the 8-bit value whose bit i is bit (n mod 32) of the high mask of pair i when n >= 32, or of the low mask of pair i when n < 32. When the syndrome is nonzero and equals the column of some data bit, the lowest such n is reported as the data index, and the single-error flag is set.
- R4: When the syndrome is nonzero and matches no data column, the check index is the position of the lowest set syndrome bit. The single-error flag is set if exactly one syndrome bit is 1; otherwise the multi-error flag is set.
- R5: An index with no faulty bit to report reads 8'hFF. A zero syndrome gives both indices 8'hFF and both error flags low.
- R6: The data output is the input word with the reported data bit inverted. When no data index is reported, the word passes through unchanged.
- R7: All results appear on the clock edge after the edge that samples the input strobe high. The result-valid output is high for exactly that one cycle per strobe.
- R8: While the input strobe is low, every result output holds its last value.
- R9: After synchronous reset, result-valid and both flags are low, both indices read 8'hFF, and the check byte, syndrome and data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input strobe: sample the word and check byte |
| in_data_hi | input | 32 | Data bits 63..32 |
| in_data_lo | input | 32 | Data bits 31..0 |
| in_chk | input | 8 | Received check byte |
| out_valid | output | 1 | Result valid, one cycle per strobe |
| out_gen_chk | output | 8 | Check byte computed from the data |
| out_syndrome | output | 8 | Generated XOR received check byte |
| out_sbe | output | 1 | Single-bit error found |
| out_mbe | output | 1 | Uncorrectable multi-bit error |
| out_data_idx | output | 8 | Failing data bit, 8'hFF if none |
| out_chk_idx | output | 8 | Failing check bit, 8'hFF if none |
| out_data | output | 64 | Corrected data word |

## Verification
The assertions assume the strobe and data inputs are known at every rising edge once reset is released. They also assume reset is synchronous, so a result-valid pulse always traces back to a strobe sampled outside reset. The stimulus changes inputs only on falling clock edges and keeps the strobe low while reset is held. Each word is strobed for exactly one cycle, so one-cycle latency and holding can be told apart.

// File: rtl/secded64_pkg.sv
package secded64_pkg;

    localparam int HALF_W = 32;
    localparam int DATA_W = 2 * HALF_W;
    localparam int CHK_W  = 8;
    localparam int IDX_W  = 8;
    localparam logic [IDX_W-1:0] IDX_NONE = '1;

    // Column masks, check bit 0 in the least significant slot.
    localparam logic [CHK_W*HALF_W-1:0] HI_MASKS = {
        32'hffff1111, 32'h8888ffff, 32'h44448888, 32'h22224444,
        32'h11113333, 32'h0f0f0f0f, 32'h00ff00ff, 32'hf00fe11e
    };
    localparam logic [CHK_W*HALF_W-1:0] LO_MASKS = {
        32'h22221114, 32'h11118882, 32'hffff4441, 32'h8888222f,
        32'h7777000f, 32'h0f0fff00, 32'h00fff0ff, 32'hc33c0ff7
    };

    function automatic logic [HALF_W-1:0] mask_hi(input int i);
        return HI_MASKS[i*HALF_W +: HALF_W];
    endfunction

    function automatic logic [HALF_W-1:0] mask_lo(input int i);
        return LO_MASKS[i*HALF_W +: HALF_W];
    endfunction

    // Syndrome produced by a lone flip of data bit n.
    function automatic logic [CHK_W-1:0] column_of(input int n);
        logic [CHK_W-1:0] col;
        for (int i = 0; i < CHK_W; i++) begin
            if (n >= HALF_W) col[i] = mask_hi(i)[n - HALF_W];
            else             col[i] = mask_lo(i)[n];
        end
        return col;
    endfunction

    typedef struct packed {
        logic              vld;
        logic [CHK_W-1:0]  gen;
        logic [CHK_W-1:0]  syn;
        logic              sbe;
        logic              mbe;
        logic [IDX_W-1:0]  didx;
        logic [IDX_W-1:0]  cidx;
        logic [DATA_W-1:0] data;
    } chk_result_t;

endpackage

// File: rtl/secded64_encoder.sv
module secded64_encoder
    import secded64_pkg::*;
(
    input  logic [HALF_W-1:0] data_hi,
    input  logic [HALF_W-1:0] data_lo,
    output logic [CHK_W-1:0]  chk
);

    // One parity tree per check bit over the masked halves.
    for (genvar i = 0; i < CHK_W; i++) begin : g_parity
        localparam logic [HALF_W-1:0] MH = mask_hi(i);
        localparam logic [HALF_W-1:0] ML = mask_lo(i);
        assign chk[i] = ^{data_hi & MH, data_lo & ML};
    end

endmodule

// File: rtl/secded64_locator.sv
module secded64_locator
    import secded64_pkg::*;
(
    input  logic [CHK_W-1:0] syn,
    output logic             data_hit,
    output logic [IDX_W-1:0] data_idx,
    output logic             chk_hit,
    output logic [IDX_W-1:0] chk_idx,
    output logic             sbe,
    output logic             mbe
);

    logic              syn_nz;
    logic              syn_single;
    logic [DATA_W-1:0] col_match;

    assign syn_nz     = |syn;
    assign syn_single = syn_nz && ((syn & (syn - 1'b1)) == '0);

    // Compare the syndrome with every data column in parallel.
    for (genvar n = 0; n < DATA_W; n++) begin : g_col
        localparam logic [CHK_W-1:0] COL = column_of(n);
        assign col_match[n] = syn_nz && (syn == COL);
    end

    // Lowest matching data bit wins.
    always_comb begin
        data_idx = IDX_NONE;
        for (int n = DATA_W - 1; n >= 0; n--) begin
            if (col_match[n]) data_idx = IDX_W'(n);
        end
    end
    assign data_hit = |col_match;

    // Lowest set syndrome bit names the check bit.
    always_comb begin
        chk_idx = IDX_NONE;
        if (!data_hit) begin
            for (int i = CHK_W - 1; i >= 0; i--) begin
                if (syn[i]) chk_idx = IDX_W'(i);
            end
        end
    end
    assign chk_hit = syn_nz && !data_hit;

    assign sbe = data_hit || (chk_hit && syn_single);
    assign mbe = chk_hit && !syn_single;

endmodule

// File: rtl/secded64_corrector.sv
module secded64_corrector
    import secded64_pkg::*;
(
    input  logic [DATA_W-1:0] data_in,
    input  logic              flip_en,
    input  logic [IDX_W-1:0]  flip_idx,
    output logic [DATA_W-1:0] data_out
);

    localparam int SEL_W = $clog2(DATA_W);

    logic [DATA_W-1:0] flip_mask;

    for (genvar n = 0; n < DATA_W; n++) begin : g_flip
        assign flip_mask[n] = flip_en && (flip_idx[SEL_W-1:0] == SEL_W'(n));
    end

    assign data_out = data_in ^ flip_mask;

endmodule

// File: rtl/secded64_checker.sv
module secded64_checker
    import secded64_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [HALF_W-1:0] in_data_hi,
    input  logic [HALF_W-1:0] in_data_lo,
    input  logic [CHK_W-1:0]  in_chk,
    output logic              out_valid,
    output logic [CHK_W-1:0]  out_gen_chk,
    output logic [CHK_W-1:0]  out_syndrome,
    output logic              out_sbe,
    output logic              out_mbe,
    output logic [IDX_W-1:0]  out_data_idx,
    output logic [IDX_W-1:0]  out_chk_idx,
    output logic [DATA_W-1:0] out_data
);

    localparam chk_result_t RESET_VAL = '{
        vld: 1'b0, gen: '0, syn: '0, sbe: 1'b0, mbe: 1'b0,
        didx: IDX_NONE, cidx: IDX_NONE, data: '0
    };

    logic [CHK_W-1:0]  gen_chk;
    logic [CHK_W-1:0]  syn;
    logic              data_hit;
    logic              chk_hit;
    logic [IDX_W-1:0]  data_idx;
    logic [IDX_W-1:0]  chk_idx;
    logic              sbe;
    logic              mbe;
    logic [DATA_W-1:0] fixed;

    chk_result_t res_d, res_q;

    secded64_encoder u_enc (
        .data_hi (in_data_hi),
        .data_lo (in_data_lo),
        .chk     (gen_chk)
    );

    assign syn = gen_chk ^ in_chk;

    secded64_locator u_loc (
        .syn      (syn),
        .data_hit (data_hit),
        .data_idx (data_idx),
        .chk_hit  (chk_hit),
        .chk_idx  (chk_idx),
        .sbe      (sbe),
        .mbe      (mbe)
    );

    secded64_corrector u_fix (
        .data_in  ({in_data_hi, in_data_lo}),
        .flip_en  (data_hit),
        .flip_idx (data_idx),
        .data_out (fixed)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        if (in_valid) begin
            res_d.gen  = gen_chk;
            res_d.syn  = syn;
            res_d.sbe  = sbe;
            res_d.mbe  = mbe;
            res_d.didx = data_idx;
            res_d.cidx = chk_idx;
            res_d.data = fixed;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= RESET_VAL;
        else     res_q <= res_d;
    end

    assign out_valid    = res_q.vld;
    assign out_gen_chk  = res_q.gen;
    assign out_syndrome = res_q.syn;
    assign out_sbe      = res_q.sbe;
    assign out_mbe      = res_q.mbe;
    assign out_data_idx = res_q.didx;
    assign out_chk_idx  = res_q.cidx;
    assign out_data     = res_q.data;

    // R2: syndrome relates the generated byte to the received one
    assert_syndrome_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_syndrome == (out_gen_chk ^ $past(in_chk)));

    // R3/R4: the two error classes never coexist
    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(out_sbe && out_mbe));

    // R3: a data index and a check index are never both reported
    assert_one_index_R3: assert property (@(posedge clk) disable iff (rst)
        !(out_data_idx != IDX_NONE && out_chk_idx != IDX_NONE));

    // R5: clean syndrome leaves everything quiet
    assert_clean_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_syndrome == '0) |->
        (!out_sbe && !out_mbe && out_data_idx == IDX_NONE && out_chk_idx == IDX_NONE));

    // R6: at most one bit differs from the sampled word, only when a data bit is named
    assert_repair_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($onehot0(out_data ^ {$past(in_data_hi), $past(in_data_lo)}) &&
                      ((out_data != {$past(in_data_hi), $past(in_data_lo)}) ==
                       (out_data_idx != IDX_NONE))));

    // R7: a result only follows a strobe
    assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R8: no strobe, no change
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_syndrome) && $stable(out_data) &&
                       $stable(out_data_idx) && $stable(out_chk_idx) && !out_valid));

endmodule

// File: tb/sim_secded64_checker.sv
module sim_secded64_checker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data_hi = '0;
    logic [31:0] in_data_lo = '0;
    logic [7:0]  in_chk = '0;
    logic        out_valid;
    logic [7:0]  out_gen_chk;
    logic [7:0]  out_syndrome;
    logic        out_sbe;
    logic        out_mbe;
    logic [7:0]  out_data_idx;
    logic [7:0]  out_chk_idx;
    logic [63:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    secded64_checker u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_data_hi(in_data_hi), .in_data_lo(in_data_lo), .in_chk(in_chk),
        .out_valid(out_valid), .out_gen_chk(out_gen_chk), .out_syndrome(out_syndrome),
        .out_sbe(out_sbe), .out_mbe(out_mbe), .out_data_idx(out_data_idx),
        .out_chk_idx(out_chk_idx), .out_data(out_data)
    );

    // Reference tables written from R1.
    function automatic logic [31:0] rm_hi(int i);
        logic [31:0] t [8] = '{32'hf00fe11e, 32'h00ff00ff, 32'h0f0f0f0f, 32'h11113333,
                               32'h22224444, 32'h44448888, 32'h8888ffff, 32'hffff1111};
        return t[i];
    endfunction
    function automatic logic [31:0] rm_lo(int i);
        logic [31:0] t [8] = '{32'hc33c0ff7, 32'h00fff0ff, 32'h0f0fff00, 32'h7777000f,
                               32'h8888222f, 32'hffff4441, 32'h11118882, 32'h22221114};
        return t[i];
    endfunction
    function automatic logic [7:0] rm_chk(logic [31:0] hi, logic [31:0] lo);
        logic [7:0] c = '0;
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 32; j++)
                c[i] = c[i] ^ (rm_hi(i)[j] & hi[j]) ^ (rm_lo(i)[j] & lo[j]);
        return c;
    endfunction
    function automatic logic [7:0] rm_col(int n);
        logic [7:0] c;
        for (int i = 0; i < 8; i++) c[i] = (n >= 32) ? rm_hi(i)[n % 32] : rm_lo(i)[n];
        return c;
    endfunction

    task automatic check(string req, string what, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Strobe one word and compare every output against the model.
    task automatic run_word(string req, logic [63:0] word, logic [7:0] rx);
        logic [7:0]  syn;
        logic [7:0]  didx = 8'hFF;
        logic [7:0]  cidx = 8'hFF;
        logic        sbe, mbe;
        logic [63:0] fixed;
        syn = rm_chk(word[63:32], word[31:0]) ^ rx;
        if (syn != 0) begin
            for (int n = 0; n < 64; n++)
                if (didx == 8'hFF && rm_col(n) == syn) didx = 8'(n);
            if (didx == 8'hFF)
                for (int i = 7; i >= 0; i--) if (syn[i]) cidx = 8'(i);
        end
        sbe   = (didx != 8'hFF) || (didx == 8'hFF && $countones(syn) == 1);
        mbe   = (syn != 0) && !sbe;
        fixed = (didx != 8'hFF) ? (word ^ (64'd1 << didx)) : word;
        @(negedge clk);
        in_data_hi = word[63:32]; in_data_lo = word[31:0]; in_chk = rx; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7", "valid", 64'(out_valid), 64'd1);
        check("R1", "gen", 64'(out_gen_chk), 64'(rm_chk(word[63:32], word[31:0])));
        check("R2", "syndrome", 64'(out_syndrome), 64'(syn));
        check("R3", "data_idx", 64'(out_data_idx), 64'(didx));
        check("R4", "chk_idx", 64'(out_chk_idx), 64'(cidx));
        check("R4", "sbe", 64'(out_sbe), 64'(sbe));
        check("R4", "mbe", 64'(out_mbe), 64'(mbe));
        check("R6", "data", out_data, fixed);
    endtask

    task automatic t_reset();
        check("R9", "valid", 64'(out_valid), 64'd0);
        check("R9", "flags", {62'd0, out_sbe, out_mbe}, 64'd0);
        check("R9", "idx", {48'd0, out_data_idx, out_chk_idx}, 64'hFFFF);
        check("R9", "data", out_data, 64'd0);
        check("R9", "syn", {48'd0, out_gen_chk, out_syndrome}, 64'd0);
    endtask

    task automatic t_clean();
        logic [63:0] w [4] = '{64'd0, 64'hFFFF_FFFF_FFFF_FFFF,
                               64'h0123_4567_89AB_CDEF, 64'hDEAD_BEEF_0BAD_F00D};
        foreach (w[k]) run_word("R5", w[k], rm_chk(w[k][63:32], w[k][31:0]));
        check("R5", "clean idx", {48'd0, out_data_idx, out_chk_idx}, 64'hFFFF);
    endtask

    task automatic t_data_flip();
        logic [63:0] base = 64'hA5A5_0F0F_3C3C_9696;
        int bits [8] = '{0, 1, 17, 31, 32, 45, 62, 63};
        foreach (bits[k])
            run_word("R3", base ^ (64'd1 << bits[k]), rm_chk(base[63:32], base[31:0]));
    endtask

    task automatic t_chk_flip();
        logic [63:0] base = 64'h1357_9BDF_2468_ACE0;
        for (int i = 0; i < 8; i++)
            run_word("R4", base, rm_chk(base[63:32], base[31:0]) ^ (8'd1 << i));
    endtask

    task automatic t_multi();
        logic [63:0] base = 64'h0F1E_2D3C_4B5A_6978;
        logic [7:0]  good = rm_chk(base[63:32], base[31:0]);
        run_word("R4", base ^ 64'h3, good);
        run_word("R4", base ^ (64'd1 << 40) ^ (64'd1 << 5), good);
        run_word("R4", base, good ^ 8'hC0);
        run_word("R4", base ^ 64'h8000_0000_0000_0001, good ^ 8'h10);
    endtask

    task automatic t_hold();
        logic [7:0]  s = out_syndrome;
        logic [63:0] d = out_data;
        logic [7:0]  di = out_data_idx;
        @(negedge clk);
        in_data_hi = 32'h5555_5555; in_data_lo = 32'hAAAA_AAAA; in_chk = 8'h77;
        repeat (3) @(negedge clk);
        check("R7", "valid low", 64'(out_valid), 64'd0);
        check("R8", "syn held", 64'(out_syndrome), 64'(s));
        check("R8", "data held", out_data, d);
        check("R8", "idx held", 64'(di), 64'(out_data_idx));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_clean();
        t_data_flip();
        t_chk_flip();
        t_multi();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule